// File: doc/BRIEF.md
# Event Timer Comparator Unit

The unit holds a free-running main counter that only counts upward, plus a small set of comparators. Each comparator watches the counter and raises its interrupt line when the count equals its target. Software reaches every register through a word-addressed port. Writes take effect at the clock edge. Reads are combinational and return the live state, including the current count.

A comparator fires only on exact equality. A target that is already behind the count is therefore missed until the counter wraps back to it. A narrow (32-bit) comparator looks only at the low 32 counter bits, while a wide one compares all 64. Comparator 0 alone can run periodically: after each match it adds a stored period to its own target. Each comparator has its own trigger choice. In edge mode the output is a single-cycle pulse. In level mode a status bit latches and holds the output until software clears the bit by writing 1 to it. A global enable starts and stops the counter and gates every interrupt output.

Word addresses: 0 global control (bit 0 = enable), 1 interrupt status (bit n = comparator n), 2 main counter. Each comparator n has a block at 4+4n (control), 5+4n (target) and 6+4n (period). Control word bits: 1 = level trigger, 2 = interrupt enable, 3 = periodic capability (read-only), 4 = periodic enable, 5 = 64-bit comparator (read-only).

Top module: `evt_timer_top`

## Requirements
- R1: While the global enable is 1 the counter rises by exactly one per clock. While it is 0 the counter holds. A read of address 2 returns the current count.
- R2: A write to address 2 loads the counter only while the global enable is 0. While the enable is 1 such a write is ignored and counting goes on.
- R3: A comparator matches only when its target equals the counter. A target already below the count never fires before wrap.
- R4: Comparators 1 and 2 are 32 bits wide and compare against counter bits 31:0. Their targets store only 32 bits. Comparator 0 compares all 64 bits.
- R5: The control word reads bit 3 = 1 only on comparator 0, and bit 5 = 1 only on comparator 0. Reset control values are 0x28, 0x00 and 0x00.
- R6: A write of control bit 4 on a comparator without periodic capability is ignored, and the bit reads back 0.
- R7: With periodic enable set, every match adds the period register to the target, so the next match comes one period later.
- R8: In edge mode (control bit 1 = 0) a match drives that interrupt bit high for exactly the one cycle after the matching count. The status bit is not set.
- R9: In level mode a match sets the status bit one cycle after the matching count. The interrupt stays high while the status is set.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: A global enable of 0 forces all interrupt outputs low while any status is kept. A comparator with control bit 2 = 0 neither pulses nor sets status.
- R12: After reset the enable, the counter, the status and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Register read data, combinational from addr_i |
| irq_o | output | NUM_CMP | Interrupt line of each comparator |

## Verification
A count value seen on the counter after edge P+k matches at edge P+k+1. Its edge pulse or level status therefore shows on irq_o in the cycle after that edge. The bench records the cycle of the enabling write and queues each expected interrupt bit against an absolute cycle number derived from (target - start count + 1). It also queues the quiet cycles on either side, and the monitor compares only in those queued cycles, away from the clock edge. Register reads are sampled combinationally in the same cycle, so counter and target values are computed from the number of edges elapsed since the enabling or disabling write.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int CMP_BASE = 4;
  localparam int CMP_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(2);

  // offsets inside a comparator block
  localparam int OFS_CFG = 0;
  localparam int OFS_TGT = 1;
  localparam int OFS_PER = 2;

  // control word bit positions
  localparam int CFG_LVL  = 1;
  localparam int CFG_IEN  = 2;
  localparam int CFG_PCAP = 3;
  localparam int CFG_PEN  = 4;
  localparam int CFG_WIDE = 5;
  localparam int CFG_W    = 6;

  typedef struct packed {
    logic wide;
    logic pen;
    logic pcap;
    logic ien;
    logic lvl;
  } cmp_cfg_t;

  function automatic logic [ADDR_W-1:0] cmp_addr(int idx, int ofs);
    return ADDR_W'(CMP_BASE + CMP_STRIDE * idx + ofs);
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(cmp_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[CFG_LVL]  = c.lvl;
    w[CFG_IEN]  = c.ien;
    w[CFG_PCAP] = c.pcap;
    w[CFG_PEN]  = c.pen;
    w[CFG_WIDE] = c.wide;
    return w;
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // software load is accepted only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_i && !en_i) begin
      cnt_q <= wdata_i;
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_comparator.sv
module evt_comparator #(
  parameter int CMP_W   = 64,
  parameter bit PER_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CMP_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic             lvl_d_i,
  input  logic             ien_d_i,
  input  logic             pen_d_i,
  input  logic             tgt_we_i,
  input  logic             per_we_i,
  input  logic [CMP_W-1:0] val_i,
  input  logic             clr_i,
  output logic             lvl_o,
  output logic             ien_o,
  output logic             pen_o,
  output logic [CMP_W-1:0] tgt_o,
  output logic [CMP_W-1:0] per_o,
  output logic             stat_o,
  output logic             irq_o
);
  logic             lvl_q, ien_q, pen_q;
  logic [CMP_W-1:0] tgt_q, per_q;
  logic             stat_q, pulse_q;
  logic             match, fire;

  assign match = en_i && (cnt_i == tgt_q);
  assign fire  = match && ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      ien_q <= 1'b0;
      pen_q <= 1'b0;
    end else if (cfg_we_i) begin
      lvl_q <= lvl_d_i;
      ien_q <= ien_d_i;
      pen_q <= PER_CAP && pen_d_i;
    end
  end

  // software write wins over periodic reload in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (tgt_we_i) begin
      tgt_q <= val_i;
    end else if (match && pen_q) begin
      tgt_q <= tgt_q + per_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
    end else if (per_we_i) begin
      per_q <= val_i;
    end
  end

  // a new level event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (fire && lvl_q) begin
        stat_q <= 1'b1;
      end else if (clr_i) begin
        stat_q <= 1'b0;
      end
      pulse_q <= fire && !lvl_q;
    end
  end

  assign irq_o  = en_i && (lvl_q ? stat_q : pulse_q);
  assign lvl_o  = lvl_q;
  assign ien_o  = ien_q;
  assign pen_o  = pen_q;
  assign tgt_o  = tgt_q;
  assign per_o  = per_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int                 NUM_CMP   = 3,
  parameter int                 CNT_W     = 64,
  parameter int                 NARROW_W  = 32,
  parameter logic [NUM_CMP-1:0] WIDE_MASK = NUM_CMP'(1),
  parameter logic [NUM_CMP-1:0] PER_MASK  = NUM_CMP'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic [NUM_CMP-1:0] irq_o
);
  logic               en_q;
  logic               cnt_wr;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_CMP-1:0] stat_vec, lvl_vec, pen_vec, stat_clr_vec;
  logic [CNT_W-1:0]   cfg_word [NUM_CMP];
  logic [CNT_W-1:0]   tgt_word [NUM_CMP];
  logic [CNT_W-1:0]   per_word [NUM_CMP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (we_i && addr_i == A_GCFG) begin
      en_q <= wdata_i[0];
    end
  end

  assign cnt_wr = we_i && (addr_i == A_CNT);

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .wr_i   (cnt_wr),
    .wdata_i(wdata_i),
    .cnt_o  (cnt_q)
  );

  for (genvar n = 0; n < NUM_CMP; n++) begin : g_cmp
    localparam int CW = WIDE_MASK[n] ? CNT_W : NARROW_W;
    localparam logic [ADDR_W-1:0] A_CFG = cmp_addr(n, OFS_CFG);
    localparam logic [ADDR_W-1:0] A_TGT = cmp_addr(n, OFS_TGT);
    localparam logic [ADDR_W-1:0] A_PER = cmp_addr(n, OFS_PER);

    logic          ien_n;
    logic [CW-1:0] tgt_n, per_n;
    cmp_cfg_t      cfg_n;

    assign stat_clr_vec[n] = we_i && (addr_i == A_STAT) && wdata_i[n];

    evt_comparator #(.CMP_W(CW), .PER_CAP(PER_MASK[n])) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q),
      .cnt_i   (cnt_q[CW-1:0]),
      .cfg_we_i(we_i && addr_i == A_CFG),
      .lvl_d_i (wdata_i[CFG_LVL]),
      .ien_d_i (wdata_i[CFG_IEN]),
      .pen_d_i (wdata_i[CFG_PEN]),
      .tgt_we_i(we_i && addr_i == A_TGT),
      .per_we_i(we_i && addr_i == A_PER),
      .val_i   (wdata_i[CW-1:0]),
      .clr_i   (stat_clr_vec[n]),
      .lvl_o   (lvl_vec[n]),
      .ien_o   (ien_n),
      .pen_o   (pen_vec[n]),
      .tgt_o   (tgt_n),
      .per_o   (per_n),
      .stat_o  (stat_vec[n]),
      .irq_o   (irq_o[n])
    );

    always_comb begin
      cfg_n      = '0;
      cfg_n.lvl  = lvl_vec[n];
      cfg_n.ien  = ien_n;
      cfg_n.pen  = pen_vec[n];
      cfg_n.pcap = PER_MASK[n];
      cfg_n.wide = WIDE_MASK[n];
    end
    assign cfg_word[n] = {{(CNT_W-CFG_W){1'b0}}, pack_cfg(cfg_n)};

    if (CW < CNT_W) begin : g_ext
      assign tgt_word[n] = {{(CNT_W-CW){1'b0}}, tgt_n};
      assign per_word[n] = {{(CNT_W-CW){1'b0}}, per_n};
    end else begin : g_full
      assign tgt_word[n] = tgt_n;
      assign per_word[n] = per_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GCFG) begin
      rdata_o[0] = en_q;
    end else if (addr_i == A_STAT) begin
      rdata_o[NUM_CMP-1:0] = stat_vec;
    end else if (addr_i == A_CNT) begin
      rdata_o = cnt_q;
    end
    for (int n = 0; n < NUM_CMP; n++) begin
      if (addr_i == cmp_addr(n, OFS_CFG)) rdata_o = cfg_word[n];
      if (addr_i == cmp_addr(n, OFS_TGT)) rdata_o = tgt_word[n];
      if (addr_i == cmp_addr(n, OFS_PER)) rdata_o = per_word[n];
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_q,
  input logic               cnt_wr,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [NUM_CMP-1:0] stat_q,
  input logic [NUM_CMP-1:0] lvl_q,
  input logic [NUM_CMP-1:0] stat_clr
);
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !cnt_wr |=> $stable(cnt_q));

  // R2
  cnt_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && cnt_wr |=> cnt_q != $past(cnt_q));

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    // R9
    stat_set_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[i]) |-> $past(lvl_q[i]) && $past(en_q));

    // R10
    stat_clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(stat_q[i]) |-> $past(stat_clr[i]));
  end
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_q    (en_q),
  .cnt_wr  (cnt_wr),
  .cnt_q   (cnt_q),
  .stat_q  (stat_vec),
  .lvl_q   (lvl_vec),
  .stat_clr(stat_clr_vec)
);

// File: tb/evt_timer_top_bench.sv
module evt_timer_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    c;
    int    idx;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  evt_timer_top u_evt_timer_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int a_cmp(int n, int ofs);
    return 4 + 4 * n + ofs;
  endfunction

  task automatic push_exp(int c, int idx, bit v, string tag);
    exp_t e;
    int i = 0;
    e.c = c; e.idx = idx; e.val = v; e.tag = tag;
    while (i < sb.size() && sb[i].c <= c) i++;
    sb.insert(i, e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].c <= cyc) begin
      if (sb[0].c == cyc) begin
        n_chk++;
        if (irq[sb[0].idx] !== sb[0].val) begin
          n_fail++;
          $display("FAIL %s cyc %0d irq[%0d] actual %0b expected %0b",
                   sb[0].tag, cyc, sb[0].idx, irq[sb[0].idx], sb[0].val);
        end
      end
      void'(sb.pop_front());
    end
  end

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] v);
    addr = 6'(a);
    #1;
    v = rdata;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, int a, logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    int n0;
    logic [63:0] v, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd_chk("R12 enable", 0, 64'h0);
    rd_chk("R12 counter", 2, 64'h0);
    rd_chk("R12 status", 1, 64'h0);
    chk("R12 irq", 64'(irq), 64'h0);
    // R5 capability and width bits
    rd_chk("R5 cfg0", a_cmp(0, 0), 64'h28);
    rd_chk("R5 cfg1", a_cmp(1, 0), 64'h00);
    rd_chk("R5 cfg2", a_cmp(2, 0), 64'h00);

    // R6 periodic enable ignored without capability
    wr(a_cmp(1, 0), 64'h14);
    rd_chk("R6 cfg1 pen", a_cmp(1, 0), 64'h04);
    wr(a_cmp(0, 0), 64'h14);
    rd_chk("R7 cfg0 pen", a_cmp(0, 0), 64'h3C);

    // periodic, edge and level run
    wr(2, 64'd100);
    rd_chk("R2 load stopped", 2, 64'd100);
    wr(a_cmp(0, 1), 64'd103);
    wr(a_cmp(0, 2), 64'd10);
    wr(a_cmp(1, 1), 64'd110);
    wr(a_cmp(2, 0), 64'h06);
    wr(a_cmp(2, 1), 64'd105);
    wr(0, 64'h1);
    n0 = cyc;
    push_exp(n0 + 3,  0, 1'b0, "R8 before pulse");
    push_exp(n0 + 4,  0, 1'b1, "R8 edge pulse");
    push_exp(n0 + 5,  0, 1'b0, "R8 single cycle");
    push_exp(n0 + 14, 0, 1'b1, "R7 periodic pulse");
    push_exp(n0 + 15, 0, 1'b0, "R7 periodic end");
    push_exp(n0 + 24, 0, 1'b1, "R7 second period");
    push_exp(n0 + 5,  2, 1'b0, "R9 before level");
    push_exp(n0 + 6,  2, 1'b1, "R9 level rise");
    push_exp(n0 + 20, 2, 1'b1, "R9 level held");
    push_exp(n0 + 30, 2, 1'b1, "R9 level still held");
    push_exp(n0 + 10, 1, 1'b0, "R3 before match");
    push_exp(n0 + 11, 1, 1'b1, "R3 exact match");
    push_exp(n0 + 12, 1, 1'b0, "R3 pulse end");
    repeat (32) @(negedge clk);
    rd_chk("R8 R9 status only level", 1, 64'h4);
    wr(0, 64'h0);
    chk("R11 irq gated", 64'(irq), 64'h0);
    rd_chk("R11 status kept", 1, 64'h4);
    rd(2, v);
    chk("R1 count", v, 64'(100 + cyc - n0));
    t = 64'd103;
    while (t < v) t += 64'd10;
    rd_chk("R7 target advanced", a_cmp(0, 1), t);
    repeat (3) @(negedge clk);
    rd_chk("R1 hold", 2, v);
    wr(1, 64'h0);
    rd_chk("R10 write zero", 1, 64'h4);
    wr(1, 64'h4);
    rd_chk("R10 write one", 1, 64'h0);

    // past target is missed; enabled counter write ignored
    wr(2, 64'd200);
    wr(a_cmp(1, 1), 64'd150);
    wr(a_cmp(0, 0), 64'h04);
    wr(a_cmp(0, 1), 64'h0);
    wr(0, 64'h1);
    n0 = cyc;
    for (int k = 1; k <= 40; k++) push_exp(n0 + k, 1, 1'b0, "R3 past target");
    repeat (42) @(negedge clk);
    wr(2, 64'd5);
    rd_chk("R2 write ignored", 2, 64'(200 + cyc - n0));
    wr(0, 64'h0);

    // narrow compare on low bits, wide needs all bits; disabled interrupt
    wr(2, 64'h1_0000_0005);
    wr(a_cmp(1, 1), 64'hAB_0000_0008);
    rd_chk("R4 narrow target", a_cmp(1, 1), 64'h8);
    wr(a_cmp(0, 1), 64'h8);
    wr(a_cmp(2, 0), 64'h02);
    wr(a_cmp(2, 1), 64'h8);
    wr(0, 64'h1);
    n0 = cyc;
    push_exp(n0 + 3, 1, 1'b0, "R4 before");
    push_exp(n0 + 4, 1, 1'b1, "R4 low bits match");
    push_exp(n0 + 5, 1, 1'b0, "R4 end");
    push_exp(n0 + 4, 0, 1'b0, "R4 wide no match");
    push_exp(n0 + 4, 2, 1'b0, "R11 int disabled");
    push_exp(n0 + 5, 2, 1'b0, "R11 int disabled late");
    repeat (8) @(negedge clk);
    rd_chk("R11 no status", 1, 64'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule